// File: doc/BRIEF.md
# I2C Master Arbitration-Loss Detector

This block watches a bus master's own intended SDA and SCL levels next to the real, already synchronized bus pins. When the two disagree in a way that means another master has taken the bus, it raises a sticky lost flag. In the same clock edge it gives a single-cycle pulse, which tells the master engine to release both lines. The block makes no clocks and no START or STOP conditions itself. It only judges what it sees.

A rule-select input chooses the second detection rule. With select low, the block checks for the SCL line being held low by someone else while this master still lets it float high. With select high, it checks for another device pulling SDA low after a START instruction and before this master has driven SDA low itself. In both settings, an SDA mismatch at an SCL rising edge during master transmit is always detected. The flag is cleared by the data-register access that fits the current direction, or by software writing 0 after it has read the flag as 1.

Top module: `arb_loss_detect`

## Requirements
- R1: After reset, `lost_flag` and `lost_pulse` are both 0.
- R2: With `is_master`=1 and `is_tx`=1, a rising edge of `pin_scl` (pin was 0 in the previous cycle and is 1 now) while `drv_sda` differs from `pin_sda` sets the flag at the next clock edge, whatever `rule_sel` is. If the levels match, nothing is set.
- R3: The SDA mismatch of R2 has no effect when `is_tx`=0 or `is_master`=0.
- R4: With `rule_sel`=0 and `is_master`=1, a falling edge of `pin_scl` while `drv_scl`=1 sets the flag. The same edge with `drv_scl`=0 does not set it.
- R5: With `rule_sel`=1, the SCL-fall condition of R4 does not set the flag.
- R6: With `rule_sel`=1, a `start_issued` pulse in master transmit with `drv_sda`=1 opens a window from the next cycle. The window closes when `drv_sda` goes to 0 or when master transmit ends. While the window is open, `pin_sda`=0 together with `drv_sda`=1 sets the flag.
- R7: A low `pin_sda` after a START instruction does not set the flag when `rule_sel`=0 or after the window has closed.
- R8: `data_wr` with `is_tx`=1, or `data_rd` with `is_tx`=0, clears the flag. `data_wr` with `is_tx`=0 does not clear it.
- R9: `flag_wr` with `flag_wdata`=0 clears the flag only if a `flag_rd` saw the flag as 1 earlier and no flag write came in between. Otherwise the write leaves the flag at 1.
- R10: When a set condition and a clear condition arrive in the same cycle, the flag ends at 1.
- R11: `lost_pulse` is 1 for exactly the one cycle in which `lost_flag` changes from 0 to 1. It stays 0 when a set condition arrives while the flag is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drv_sda | input | 1 | SDA level this master intends (1 = released) |
| drv_scl | input | 1 | SCL level this master intends (1 = released) |
| pin_sda | input | 1 | Synchronized SDA bus pin |
| pin_scl | input | 1 | Synchronized SCL bus pin |
| is_master | input | 1 | Master mode |
| is_tx | input | 1 | Transmit mode (0 = receive) |
| start_issued | input | 1 | One-cycle pulse: START instruction issued |
| rule_sel | input | 1 | 0 = SCL-high rule, 1 = early-SDA rule |
| data_wr | input | 1 | Data register write strobe |
| data_rd | input | 1 | Data register read strobe |
| flag_rd | input | 1 | Flag read strobe |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Value written to the flag |
| lost_flag | output | 1 | Sticky arbitration-lost flag |
| lost_pulse | output | 1 | One-cycle release request on flag set |

## Verification
The SDA-mismatch rule is driven with a mismatch, with matching levels, in receive mode and in slave mode. This separates the edge qualification from the mode gating. The SCL rule is driven with the internal SCL both released and driven low, under each rule-select value. The early-SDA rule is driven inside the window, after the window has closed, and with the other rule selected, so that a leak of either rule into the wrong setting shows up at the flag. The clear paths are driven with strobes in the right direction and the wrong direction, with software writes made with and without a prior read, and together with a set in the same cycle, from both flag states.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic {
      RULE_SCL_HIGH  = 1'b0,
      RULE_EARLY_SDA = 1'b1
   } rule_sel_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } scl_edges_t;
endpackage

// File: rtl/arb_scl_edge.sv
module arb_scl_edge #(
   parameter int unsigned SCL_IDLE = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pin_scl,
   output arb_pkg::scl_edges_t edges
);
   localparam logic IDLE_LVL = (SCL_IDLE != 0);

   if (SCL_IDLE > 1) begin : g_bad_idle
      $error("SCL_IDLE must be 0 or 1");
   end

   logic scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= IDLE_LVL;
      else        scl_q <= pin_scl;
   end

   always_comb begin
      edges.rise = pin_scl & ~scl_q;
      edges.fall = ~pin_scl & scl_q;
   end
endmodule

// File: rtl/arb_rule_eval.sv
module arb_rule_eval #(
   parameter int unsigned EARLY_SDA_EN = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  arb_pkg::scl_edges_t edges,
   input  logic                drv_sda,
   input  logic                drv_scl,
   input  logic                pin_sda,
   input  logic                is_master,
   input  logic                is_tx,
   input  logic                start_issued,
   input  arb_pkg::rule_sel_e  rule_sel,
   output logic                set_req
);
   import arb_pkg::*;

   if (EARLY_SDA_EN > 1) begin : g_bad_en
      $error("EARLY_SDA_EN must be 0 or 1");
   end

   logic mtx;
   logic sda_conflict;
   logic scl_conflict;
   logic early_conflict;

   assign mtx          = is_master & is_tx;
   assign sda_conflict = mtx & edges.rise & (drv_sda ^ pin_sda);
   assign scl_conflict = (rule_sel == RULE_SCL_HIGH) & is_master & edges.fall & drv_scl;

   if (EARLY_SDA_EN != 0) begin : g_early
      logic win_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              win_q <= 1'b0;
         else if (start_issued && mtx && drv_sda) win_q <= 1'b1;
         else if (!drv_sda || !mtx)               win_q <= 1'b0;
      end

      assign early_conflict = (rule_sel == RULE_EARLY_SDA) & win_q & mtx
                              & drv_sda & ~pin_sda;

      AST_WINDOW_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
         (!drv_sda && !start_issued) |=> !win_q); // R6
   end else begin : g_no_early
      assign early_conflict = 1'b0;
   end

   assign set_req = sda_conflict | scl_conflict | early_conflict;

   AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_master) |-> !set_req); // R3
endmodule

// File: rtl/arb_flag_reg.sv
module arb_flag_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic hw_clr,
   input  logic flag_rd,
   input  logic flag_wr,
   input  logic flag_wdata,
   output logic flag_q,
   output logic pulse_q
);
   logic seen_one_q;
   logic sw_clr;

   assign sw_clr = flag_wr & ~flag_wdata & seen_one_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q     <= 1'b0;
         pulse_q    <= 1'b0;
         seen_one_q <= 1'b0;
      end else begin
         pulse_q <= set_req & ~flag_q;
         if (set_req)              flag_q <= 1'b1;
         else if (hw_clr || sw_clr) flag_q <= 1'b0;
         if (flag_wr)              seen_one_q <= 1'b0;
         else if (flag_rd && flag_q) seen_one_q <= 1'b1;
         else if (!flag_q)          seen_one_q <= 1'b0;
      end
   end

   AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> flag_q); // R11
   AST_RISE_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> pulse_q); // R11
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q); // R11
endmodule

// File: rtl/arb_loss_detect.sv
module arb_loss_detect #(
   parameter int unsigned EARLY_SDA_EN = 1,
   parameter int unsigned SCL_IDLE     = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic drv_sda,
   input  logic drv_scl,
   input  logic pin_sda,
   input  logic pin_scl,
   input  logic is_master,
   input  logic is_tx,
   input  logic start_issued,
   input  logic rule_sel,
   input  logic data_wr,
   input  logic data_rd,
   input  logic flag_rd,
   input  logic flag_wr,
   input  logic flag_wdata,
   output logic lost_flag,
   output logic lost_pulse
);
   import arb_pkg::*;

   scl_edges_t edges;
   rule_sel_e  sel;
   logic       set_req;
   logic       hw_clr;

   assign sel    = rule_sel_e'(rule_sel);
   assign hw_clr = (data_wr & is_tx) | (data_rd & ~is_tx);

   arb_scl_edge #(.SCL_IDLE(SCL_IDLE)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_scl (pin_scl),
      .edges   (edges)
   );

   arb_rule_eval #(.EARLY_SDA_EN(EARLY_SDA_EN)) u_rules (
      .clk          (clk),
      .rst_n        (rst_n),
      .edges        (edges),
      .drv_sda      (drv_sda),
      .drv_scl      (drv_scl),
      .pin_sda      (pin_sda),
      .is_master    (is_master),
      .is_tx        (is_tx),
      .start_issued (start_issued),
      .rule_sel     (sel),
      .set_req      (set_req)
   );

   arb_flag_reg u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_req    (set_req),
      .hw_clr     (hw_clr),
      .flag_rd    (flag_rd),
      .flag_wr    (flag_wr),
      .flag_wdata (flag_wdata),
      .flag_q     (lost_flag),
      .pulse_q    (lost_pulse)
   );

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> lost_flag); // R10
   AST_HOLD_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_flag && !hw_clr && !flag_wr) |=> lost_flag); // R9
   AST_SDA_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (is_master && is_tx && edges.rise && (drv_sda != pin_sda)) |=> lost_flag); // R2
endmodule

// File: tb/arb_loss_detect_tb_top.sv
`timescale 1ns/1ps
module arb_loss_detect_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic drv_sda = 1'b1, drv_scl = 1'b1, pin_sda = 1'b1, pin_scl = 1'b1;
   logic is_master = 1'b1, is_tx = 1'b1, start_issued = 1'b0, rule_sel = 1'b0;
   logic data_wr = 1'b0, data_rd = 1'b0, flag_rd = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
   logic lost_flag, lost_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic  f;
      logic  p;
      string req;
   } exp_t;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   arb_loss_detect dut_i (
      .clk(clk), .rst_n(rst_n), .drv_sda(drv_sda), .drv_scl(drv_scl),
      .pin_sda(pin_sda), .pin_scl(pin_scl), .is_master(is_master), .is_tx(is_tx),
      .start_issued(start_issued), .rule_sel(rule_sel), .data_wr(data_wr),
      .data_rd(data_rd), .flag_rd(flag_rd), .flag_wr(flag_wr),
      .flag_wdata(flag_wdata), .lost_flag(lost_flag), .lost_pulse(lost_pulse)
   );

   // driver: inputs already set at this negedge; expectation is for after the next posedge
   task automatic tick(input logic f, input logic p, input string req);
      exp_t e;
      e.f = f; e.p = p; e.req = req;
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   // monitor
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (lost_flag !== e.f || lost_pulse !== e.p) begin
            errors++;
            $display("FAIL %s: flag/pulse actual %b%b expected %b%b at %0t",
                     e.req, lost_flag, lost_pulse, e.f, e.p, $time);
         end
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      tick(0, 0, "R1 reset");
      tick(0, 0, "R1 reset");
      rst_n = 1'b1;
      tick(0, 0, "R1 idle");
      // R2 mismatch at rise
      pin_scl = 0; drv_scl = 0; tick(0, 0, "R2 prep");
      pin_scl = 1; drv_scl = 1; pin_sda = 0; tick(1, 1, "R2 set");
      tick(1, 0, "R11 single pulse");
      pin_sda = 1;
      data_wr = 1; tick(0, 0, "R8 wr in tx"); data_wr = 0;
      // R2 matching levels
      pin_scl = 0; drv_scl = 0; drv_sda = 0; pin_sda = 0; tick(0, 0, "R2 prep");
      pin_scl = 1; drv_scl = 1; tick(0, 0, "R2 match");
      drv_sda = 1; pin_sda = 1;
      // R3 receive and slave
      is_tx = 0;
      pin_scl = 0; drv_scl = 0; tick(0, 0, "R3 prep");
      pin_scl = 1; drv_scl = 1; pin_sda = 0; tick(0, 0, "R3 rx");
      pin_sda = 1;
      pin_scl = 0; drv_scl = 0; tick(0, 0, "R3 prep");
      is_master = 0; is_tx = 1;
      pin_scl = 1; drv_scl = 1; pin_sda = 0; tick(0, 0, "R3 slave");
      pin_sda = 1; is_master = 1; is_tx = 0;
      // R4 SCL rule, receive mode
      pin_scl = 0; drv_scl = 1; tick(1, 1, "R4 set");
      data_rd = 1; tick(0, 0, "R8 rd in rx"); data_rd = 0;
      pin_scl = 1; tick(0, 0, "R4 prep");
      pin_scl = 0; tick(1, 1, "R4 set again");
      data_wr = 1; tick(1, 0, "R8 wr in rx ignored"); data_wr = 0;
      data_rd = 1; tick(0, 0, "R8 rd in rx"); data_rd = 0;
      pin_scl = 1; drv_scl = 1; tick(0, 0, "R4 prep");
      pin_scl = 0; drv_scl = 0; tick(0, 0, "R4 no conflict");
      // R5
      pin_scl = 1; drv_scl = 1; tick(0, 0, "R5 prep");
      rule_sel = 1;
      pin_scl = 0; drv_scl = 1; tick(0, 0, "R5 SCL rule off");
      drv_scl = 0;
      // R6 early SDA
      is_tx = 1;
      pin_scl = 1; drv_scl = 1; tick(0, 0, "R6 prep");
      start_issued = 1; tick(0, 0, "R6 start");
      start_issued = 0; pin_sda = 0; tick(1, 1, "R6 early pull");
      pin_sda = 1; drv_sda = 0; flag_rd = 1; tick(1, 0, "R9 read");
      flag_rd = 0; drv_sda = 1;
      flag_wr = 1; flag_wdata = 0; tick(0, 0, "R9 write0 after read"); flag_wr = 0;
      // R7 window closed
      start_issued = 1; tick(0, 0, "R7 start");
      start_issued = 0; drv_sda = 0; pin_sda = 0; tick(0, 0, "R7 own low");
      drv_sda = 1; pin_sda = 0; tick(0, 0, "R7 after close");
      pin_sda = 1; tick(0, 0, "R7 idle");
      // R7 other rule
      rule_sel = 0;
      start_issued = 1; tick(0, 0, "R7 start sel0");
      start_issued = 0; pin_sda = 0; tick(0, 0, "R7 sel0 ignored");
      pin_sda = 1; tick(0, 0, "R7 idle");
      // R9 write without read
      pin_scl = 0; drv_scl = 0; tick(0, 0, "R9 prep");
      pin_scl = 1; drv_scl = 1; pin_sda = 0; tick(1, 1, "R2 set");
      pin_sda = 1;
      flag_wr = 1; flag_wdata = 0; tick(1, 0, "R9 write0 no read"); flag_wr = 0;
      flag_rd = 1; tick(1, 0, "R9 read"); flag_rd = 0;
      flag_wr = 1; flag_wdata = 0; tick(0, 0, "R9 write0 after read"); flag_wr = 0;
      // R10 set wins
      pin_scl = 0; drv_scl = 0; tick(0, 0, "R10 prep");
      pin_scl = 1; drv_scl = 1; pin_sda = 0; data_wr = 1; tick(1, 1, "R10 from 0");
      pin_sda = 1; data_wr = 0;
      pin_scl = 0; drv_scl = 0; tick(1, 0, "R10 prep");
      pin_scl = 1; drv_scl = 1; pin_sda = 0; data_wr = 1; tick(1, 0, "R10 from 1 / R11 no pulse");
      data_wr = 0; pin_sda = 1; tick(1, 0, "R11 hold");
      data_wr = 1; tick(0, 0, "R8 wr in tx"); data_wr = 0;
      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule